// File: doc/BRIEF.md
# Three-Phase Three-Level Hysteresis Current Controller

This block closes the current loop of a three-leg inverter with a band comparator per phase. On every sample strobe it takes a signed reference current and a signed measured current for each of the three phases and forms the error as reference minus measured. It keeps a three-valued output state per phase: drive positive, drive negative, or rest at zero. From that state it produces the gate commands for the upper and lower switch of the leg.

In the default three-level mode an outer band of width `h` forces an active output. An inner boundary of width `del` around zero error returns the leg to the zero output. Between the two boundaries the leg keeps its last state. If the zero output does not turn the current around, the error runs on to the opposite outer band, and the opposite active output follows. A mode input selects the conventional two-level comparator instead. In that mode the switching points are at half the outer band and the two gates are always complementary. Both band widths are runtime inputs and must satisfy `0 <= del < h`.

Top module: `tri_band_current_ctrl`

## Requirements
- R1: After reset every phase is in the zero state (code 0) with both gates off, and stays so until the first sample strobe.
- R2: The error of each phase is reference minus measured. Both are CUR_W-bit two's complement values, and the error is formed one bit wider so that it never wraps. Phase a uses bits [CUR_W-1:0] of each packed bus, phase b the next CUR_W bits, and phase c the top CUR_W bits.
- R3: In three-level mode, a strobe with error >= h sets the phase state to positive (code 1).
- R4: In three-level mode, a strobe with error <= -h sets the phase state to negative (code 2).
- R5: In three-level mode, a strobe with -del <= error <= del sets the phase state to zero (code 0). When the bands overlap, the outer band takes precedence.
- R6: In three-level mode, a strobe with error strictly between the inner boundary and the outer band keeps the previous state. A leg that was switched to zero therefore stays at zero until the error reaches an outer band, including the opposite one.
- R7: The gates follow the state. Positive turns the upper gate on and the lower gate off, negative does the reverse, and zero turns both off. Both gates are never on together.
- R8: In two-level mode, with half = h >> 1, a strobe with error > half sets positive and a strobe with error < -half sets negative. Inside that window a positive state stays positive and any other state becomes negative, so after one strobe exactly one gate of the leg is on.
- R9: State and gates change only on the clock edge where sampleValid is high, and they show the new value right after that edge. Without a strobe they hold.
- R10: The three phases are evaluated independently, each from its own reference and measured current.
- R11: The exported per-phase 2-bit state code (phase p at bits [2p+1:2p]) is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe marking a new set of current samples |
| twoLevelMode | input | 1 | 1 selects the two-level comparator, 0 selects three-level |
| bandOuter | input | CUR_W | Outer band width h, unsigned |
| bandInner | input | CUR_W | Inner boundary width del, unsigned |
| refCur | input | PHASES*CUR_W | Packed signed reference currents, phase a in the low bits |
| actCur | input | PHASES*CUR_W | Packed signed measured currents, phase a in the low bits |
| stateCode | output | 2*PHASES | Per-phase state code: 0 zero, 1 positive, 2 negative |
| gateHigh | output | PHASES | Upper switch command per phase |
| gateLow | output | PHASES | Lower switch command per phase |

## Verification
On every cycle the assertions check four things: the state code is never 3, the two gates of a leg are never on together and match the state, state and gates hold without a strobe, and two-level strobes leave exactly one gate on. They also check that reaching an outer band forces the matching active state. Some behaviour only the bench scenarios can show. These are the memory between the inner and outer bands, the crossing from zero to the opposite active state, the exact threshold equalities, the non-wrapping error at full-scale inputs, and the independence of the three phases. The bench shows them by comparing all phases against a reference model under directed and random currents and bands.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

  typedef enum logic [1:0] {
    ST_ZERO = 2'd0,
    ST_POS  = 2'd1,
    ST_NEG  = 2'd2
  } legState_t;

  // strobes from the top to every leg
  typedef struct packed {
    logic advance;
    logic twoLevel;
  } legStrobe_t;

  // comparison results from the error datapath to the leg control
  typedef struct packed {
    logic reachPos;   // err >= h
    logic reachNeg;   // err <= -h
    logic inInner;    // |err| <= del
    logic overHalf;   // err > h>>1
    logic underHalf;  // err < -(h>>1)
  } bandHits_t;

endpackage

// File: rtl/hcc_err_dp.sv
module hcc_err_dp #(
  parameter int CUR_W = 16
) (
  input  logic [CUR_W-1:0]  refVal,
  input  logic [CUR_W-1:0]  actVal,
  input  logic [CUR_W-1:0]  bandOuter,
  input  logic [CUR_W-1:0]  bandInner,
  output hcc_pkg::bandHits_t hits
);
  localparam int ERR_W = CUR_W + 1;

  logic signed [ERR_W-1:0] errVal;
  logic signed [ERR_W-1:0] outerP, outerN;
  logic signed [ERR_W-1:0] innerP, innerN;
  logic signed [ERR_W-1:0] halfP, halfN;

  always_comb begin
    // sign-extend by one bit so the difference never wraps
    errVal = $signed({refVal[CUR_W-1], refVal}) - $signed({actVal[CUR_W-1], actVal});
    outerP = $signed({1'b0, bandOuter});
    outerN = -outerP;
    innerP = $signed({1'b0, bandInner});
    innerN = -innerP;
    halfP  = $signed({2'b00, bandOuter[CUR_W-1:1]});
    halfN  = -halfP;
  end

  always_comb begin
    hits.reachPos  = (errVal >= outerP);
    hits.reachNeg  = (errVal <= outerN);
    hits.inInner   = (errVal <= innerP) && (errVal >= innerN);
    hits.overHalf  = (errVal > halfP);
    hits.underHalf = (errVal < halfN);
  end

endmodule

// File: rtl/hcc_leg_ctrl.sv
module hcc_leg_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  hcc_pkg::legStrobe_t strobe,
  input  hcc_pkg::bandHits_t  hits,
  output logic [1:0]          stateCode,
  output logic                gateHigh,
  output logic                gateLow
);
  import hcc_pkg::*;

  legState_t stateQ, stateNext;
  logic      gateHighQ, gateLowQ;
  logic      gateHighNext, gateLowNext;

  // next-state selection
  always_comb begin
    stateNext = stateQ;
    if (strobe.twoLevel) begin
      if (hits.overHalf)        stateNext = ST_POS;
      else if (hits.underHalf)  stateNext = ST_NEG;
      else if (stateQ != ST_POS) stateNext = ST_NEG;
    end else begin
      if (hits.reachPos)        stateNext = ST_POS;
      else if (hits.reachNeg)   stateNext = ST_NEG;
      else if (hits.inInner)    stateNext = ST_ZERO;
    end
  end

  // gate decode; any other code acts as zero
  always_comb begin
    case (stateNext)
      ST_POS:  begin gateHighNext = 1'b1; gateLowNext = 1'b0; end
      ST_NEG:  begin gateHighNext = 1'b0; gateLowNext = 1'b1; end
      default: begin gateHighNext = 1'b0; gateLowNext = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ    <= ST_ZERO;
      gateHighQ <= 1'b0;
      gateLowQ  <= 1'b0;
    end else if (strobe.advance) begin
      stateQ    <= stateNext;
      gateHighQ <= gateHighNext;
      gateLowQ  <= gateLowNext;
    end
  end

  assign stateCode = stateQ;
  assign gateHigh  = gateHighQ;
  assign gateLow   = gateLowQ;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    stateQ != 2'd3); // R11
  AST_NO_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHighQ && gateLowQ)); // R7
  AST_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (gateHighQ == (stateQ == ST_POS)) && (gateLowQ == (stateQ == ST_NEG))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(stateQ) && $stable(gateHighQ) && $stable(gateLowQ)); // R9
  AST_TWO_LEVEL_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && strobe.twoLevel |=> gateHighQ != gateLowQ); // R8
  AST_OUTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !strobe.twoLevel && hits.reachPos |=> stateQ == ST_POS); // R3
  AST_OUTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !strobe.twoLevel && hits.reachNeg && !hits.reachPos |=> stateQ == ST_NEG); // R4

endmodule

// File: rtl/tri_band_current_ctrl.sv
module tri_band_current_ctrl #(
  parameter int CUR_W  = 16,
  parameter int PHASES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sampleValid,
  input  logic                      twoLevelMode,
  input  logic [CUR_W-1:0]          bandOuter,
  input  logic [CUR_W-1:0]          bandInner,
  input  logic [PHASES*CUR_W-1:0]   refCur,
  input  logic [PHASES*CUR_W-1:0]   actCur,
  output logic [2*PHASES-1:0]       stateCode,
  output logic [PHASES-1:0]         gateHigh,
  output logic [PHASES-1:0]         gateLow
);
  import hcc_pkg::*;

  legStrobe_t strobe;

  always_comb begin
    strobe.advance  = sampleValid;
    strobe.twoLevel = twoLevelMode;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    bandHits_t hits;

    hcc_err_dp #(.CUR_W(CUR_W)) i_dp (
      .refVal    (refCur[p*CUR_W +: CUR_W]),
      .actVal    (actCur[p*CUR_W +: CUR_W]),
      .bandOuter (bandOuter),
      .bandInner (bandInner),
      .hits      (hits)
    );

    hcc_leg_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe),
      .hits      (hits),
      .stateCode (stateCode[2*p +: 2]),
      .gateHigh  (gateHigh[p]),
      .gateLow   (gateLow[p])
    );
  end

endmodule

// File: tb/test_tri_band_current_ctrl.sv
module test_tri_band_current_ctrl;
  localparam int CUR_W = 16;
  localparam int PH    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic twoLevelMode = 1'b0;
  logic [CUR_W-1:0] bandOuter = '0;
  logic [CUR_W-1:0] bandInner = '0;
  logic [PH*CUR_W-1:0] refCur = '0;
  logic [PH*CUR_W-1:0] actCur = '0;
  logic [2*PH-1:0] stateCode;
  logic [PH-1:0] gateHigh, gateLow;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  int mState [PH];
  string mTag [PH];

  always #5 clk = ~clk;

  tri_band_current_ctrl #(.CUR_W(CUR_W), .PHASES(PH)) i_tri_band_current_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .twoLevelMode(twoLevelMode),
    .bandOuter(bandOuter), .bandInner(bandInner), .refCur(refCur), .actCur(actCur),
    .stateCode(stateCode), .gateHigh(gateHigh), .gateLow(gateLow));

  function automatic void stepModel(int p, int err, int h, int d, bit two);
    int half = h / 2;
    if (two) begin
      if (err > half)       begin mState[p] = 1; mTag[p] = "R8"; end
      else if (err < -half) begin mState[p] = 2; mTag[p] = "R8"; end
      else begin
        if (mState[p] != 1) mState[p] = 2;
        mTag[p] = "R8";
      end
    end else begin
      if (err >= h)                     begin mState[p] = 1; mTag[p] = "R3"; end
      else if (err <= -h)               begin mState[p] = 2; mTag[p] = "R4"; end
      else if (err <= d && err >= -d)   begin mState[p] = 0; mTag[p] = "R5"; end
      else                              mTag[p] = "R6";
    end
  endfunction

  task automatic checkAll(string scen);
    for (int p = 0; p < PH; p++) begin
      int expHi = (mState[p] == 1) ? 1 : 0;
      int expLo = (mState[p] == 2) ? 1 : 0;
      total++;
      if (int'(stateCode[2*p +: 2]) != mState[p]) begin
        bad++;
        $display("FAIL %s %s phase %0d state actual=%0d expected=%0d", mTag[p], scen, p,
                 stateCode[2*p +: 2], mState[p]);
      end
      total++;
      if (int'(gateHigh[p]) != expHi || int'(gateLow[p]) != expLo) begin
        bad++;
        $display("FAIL R7 %s %s phase %0d gates actual=%0d%0d expected=%0d%0d", mTag[p], scen, p,
                 gateHigh[p], gateLow[p], expHi, expLo);
      end
      total++;
      if (stateCode[2*p +: 2] == 2'd3) begin
        bad++;
        $display("FAIL R11 phase %0d state actual=3 expected=0..2", p);
      end
    end
  endtask

  // check the result of the previous step, then apply the next one
  task automatic step(string scen, bit valid, bit two, int h, int d,
                      int r0, int a0, int r1, int a1, int r2, int a2);
    int rv [PH];
    int av [PH];
    @(negedge clk);
    checkAll(scen);
    rv[0] = r0; rv[1] = r1; rv[2] = r2;
    av[0] = a0; av[1] = a1; av[2] = a2;
    sampleValid  = valid;
    twoLevelMode = two;
    bandOuter    = CUR_W'(h);
    bandInner    = CUR_W'(d);
    for (int p = 0; p < PH; p++) begin
      refCur[p*CUR_W +: CUR_W] = CUR_W'(rv[p]);
      actCur[p*CUR_W +: CUR_W] = CUR_W'(av[p]);
      if (valid) stepModel(p, rv[p] - av[p], h, d, two);
      else mTag[p] = "R9";
    end
  endtask

  initial begin
    for (int p = 0; p < PH; p++) begin mState[p] = 0; mTag[p] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1 reset");
    rst_n = 1'b1;
    // R1: still idle without strobe
    step("R1 idle", 0, 0, 100, 20, 500, 0, -500, 0, 0, 0);
    // R10 phases differ; R3/R4 boundary equality and R6 hold
    step("R10 outer", 1, 0, 100, 20, 100, 0, 0, 100, 99, 0);
    step("R10 inner", 1, 0, 100, 20, 20, 0, 0, 20, 101, 0);
    step("R6 hold", 1, 0, 100, 20, 50, 0, 0, 21, 0, 50);
    step("R6 cross", 1, 0, 100, 20, -21, 0, 0, -99, 0, 21);
    step("R6 opposite", 1, 0, 100, 20, -100, 0, 99, 0, 0, 100);
    step("R5 inner", 1, 0, 100, 20, -20, 0, 0, 0, 3, 5);
    step("R3 again", 1, 0, 100, 20, 300, 0, 0, 300, 300, 0);
    // R9: no strobe, large error must not act
    step("R9 nostrobe", 0, 0, 100, 20, -900, 0, 900, 0, 0, 900);
    step("R9 nostrobe2", 0, 1, 100, 20, 0, 0, 0, 0, 0, 0);
    // R8 two-level, half = 50
    step("R8 in-window", 1, 1, 100, 20, 50, 0, 0, 0, -50, 0);
    step("R8 above", 1, 1, 100, 20, 51, 0, 0, 0, -51, 0);
    step("R8 hold", 1, 1, 100, 20, -50, 0, 50, 0, 0, 0);
    step("R8 below", 1, 1, 100, 20, -51, 0, 51, 0, 0, 51);
    // R2 full-scale error, no wrap
    step("R2 max", 1, 0, 65535, 0, 32767, -32768, -32768, 32767, 0, 0);
    step("R2 max2", 1, 0, 65535, 65534, -32768, 32767, 32767, -32768, 1, 0);
    step("R2 wrapcheck", 1, 0, 1000, 10, 32767, -32768, -32768, 32767, -32768, -32768);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int h = 1 + int'($urandom_range(0, 3999));
      int d = int'($urandom_range(0, 32'(h - 1)));
      int rr [PH];
      int aa [PH];
      for (int p = 0; p < PH; p++) begin
        rr[p] = int'($urandom_range(0, 20000)) - 10000;
        aa[p] = rr[p] - (int'($urandom_range(0, 2 * (h + 400))) - (h + 400));
      end
      step("R10 random", ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0), h, d,
           rr[0], aa[0], rr[1], aa[1], rr[2], aa[2]);
    end
    step("R9 final", 0, 0, 100, 20, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    checkAll("R9 final");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial $urandom(1234);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule